// File: doc/BRIEF.md
# Audio Bus Clock Generator with Idle Gap

This block drives the clock side of a PCM or I2S codec port when the chip is the bus master. It divides the system clock down to a bit clock and counts bit-clock ticks to mark frames. At tick 0 of every frame it raises a frame-sync pulse that lasts one tick. The serializers get two helpers: the tick index within the frame, and a flag that says when data may move.

A frame can carry an idle gap. The gap covers the ticks from a programmed start position up to, but not including, a programmed stop position. During the gap the bit clock stays at 0, so the codec sees fewer edges per frame while the frame period is unchanged. The data-window flag drops at the gap start and stays low until the frame ends, so every transfer finishes before the clock pauses.

The controller has five states:
- `ST_OFF`: disabled.
- `ST_HIGH`: the first half of a clocked tick.
- `ST_LOW`: the second half of a clocked tick.
- `ST_GAP_A`: the first half of a gap tick.
- `ST_GAP_B`: the second half of a gap tick.

The transitions are:
- OFF to HIGH or GAP_A on enable.
- HIGH to LOW after one half period.
- GAP_A to GAP_B after one half period.
- LOW or GAP_B to HIGH or GAP_A at the end of each tick. The choice depends on whether the next position lies in the gap.
- Any state to OFF when enable drops.

A configuration is captured only at a frame boundary, and only if it passes validation.

Top module: `audio_clkgen`

## Requirements
- R1: Each bit-clock tick lasts 2*div system cycles. In a clocked tick the bit clock is high for the first div cycles and low for the next div cycles. A frame lasts len ticks. bit_pos counts 0 to len-1 and then wraps.
- R2: fsync is high for exactly one tick, the tick at bit_pos 0, which is 2*div system cycles.
- R3: When idle_start differs from idle_stop, ticks whose position p satisfies idle_start <= p < idle_stop show no bit-clock pulse. Each frame then has len-(idle_stop-idle_start) rising edges.
- R4: When a gap is in use, data_win is high only in ticks with position below idle_start. That gives idle_start*2*div cycles per frame.
- R5: When idle_start equals idle_stop, there is no gap. All len ticks pulse and data_win is high for the whole frame.
- R6: A configuration is rejected and the previous one is kept if any of these holds: div is 0, len is below 2, idle_stop exceeds len, or idle_start exceeds idle_stop.
- R7: A configuration change on the inputs takes effect only from the next frame start. The frame in progress finishes with the settings it started with.
- R8: While enable is low, and one cycle after it drops, bclk, fsync and data_win are 0 and bit_pos is 0. The state after reset is the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the generator while high |
| cfg_div | input | 8 | Half bit-clock period in system cycles |
| cfg_len | input | 8 | Frame length in bit-clock ticks |
| cfg_idle_start | input | 8 | First tick of the idle gap |
| cfg_idle_stop | input | 8 | First tick after the idle gap |
| bclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame-sync pulse, one tick wide |
| data_win | output | 1 | High while data transfer is allowed |
| bit_pos | output | 8 | Tick index within the frame |

## Verification
The bench builds the block with its default parameters: 8-bit position and divider widths, and a reset configuration of a 32-tick frame with no gap. Frames are set to 8 to 20 ticks and half periods to 1 to 3 system cycles, so many whole frames fit in a short run. These values cover:
- a gap that starts at tick 0,
- a gap that ends exactly at the frame length,
- equal start and stop positions,
- both kinds of rejected configuration (stop beyond len, and start after stop).

Each new configuration is applied mid-frame, so the boundary-only capture is tested every time the configuration changes.

// File: rtl/gap_clkgen_pkg.sv
package gap_clkgen_pkg;

    parameter int CG_POS_W = 8;
    parameter int CG_DIV_W = 8;

    typedef struct packed {
        logic [CG_DIV_W-1:0] div;
        logic [CG_POS_W-1:0] len;
        logic [CG_POS_W-1:0] idle_start;
        logic [CG_POS_W-1:0] idle_stop;
    } gen_cfg_t;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_HIGH,
        ST_LOW,
        ST_GAP_A,
        ST_GAP_B
    } gen_state_t;

    function automatic logic cfg_ok(gen_cfg_t c);
        return (c.div != '0) && (c.len >= CG_POS_W'(2)) &&
               (c.idle_stop <= c.len) && (c.idle_start <= c.idle_stop);
    endfunction

    function automatic logic tick_in_gap(gen_cfg_t c, logic [CG_POS_W-1:0] p);
        return (c.idle_start != c.idle_stop) && (p >= c.idle_start) &&
               (p < c.idle_stop);
    endfunction

endpackage

// File: rtl/gap_cfg_shadow.sv
module gap_cfg_shadow
    import gap_clkgen_pkg::*;
#(
    parameter gen_cfg_t RST_CFG = '0
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  gen_cfg_t cfg_in,
    output gen_cfg_t act_cfg,
    output gen_cfg_t nxt_cfg
);

    always_comb nxt_cfg = cfg_ok(cfg_in) ? cfg_in : act_cfg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            act_cfg <= RST_CFG;
        else if (load)
            act_cfg <= nxt_cfg;
    end

endmodule

// File: rtl/gap_half_div.sv
module gap_half_div
    import gap_clkgen_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic [CG_DIV_W-1:0] div,
    output logic                half_done
);

    logic [CG_DIV_W-1:0] cnt_q;

    assign half_done = run && (cnt_q == div - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || half_done)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
    import gap_clkgen_pkg::*;
#(
    parameter int DEF_DIV   = 1,
    parameter int DEF_LEN   = 32,
    parameter int DEF_START = 0,
    parameter int DEF_STOP  = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic [CG_DIV_W-1:0] cfg_div,
    input  logic [CG_POS_W-1:0] cfg_len,
    input  logic [CG_POS_W-1:0] cfg_idle_start,
    input  logic [CG_POS_W-1:0] cfg_idle_stop,
    output logic                bclk,
    output logic                fsync,
    output logic                data_win,
    output logic [CG_POS_W-1:0] bit_pos
);

    localparam gen_cfg_t RST_CFG = '{
        div:        CG_DIV_W'(DEF_DIV),
        len:        CG_POS_W'(DEF_LEN),
        idle_start: CG_POS_W'(DEF_START),
        idle_stop:  CG_POS_W'(DEF_STOP)
    };

    gen_state_t          state_q, state_d;
    logic [CG_POS_W-1:0] pos_q, pos_d, pos_inc;
    gen_cfg_t            cfg_in, act_q, nxt_cfg;
    logic                load, run, half_done, tick_end, wrap;

    assign cfg_in = '{div: cfg_div, len: cfg_len,
                      idle_start: cfg_idle_start, idle_stop: cfg_idle_stop};

    gap_cfg_shadow #(.RST_CFG(RST_CFG)) u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .cfg_in  (cfg_in),
        .act_cfg (act_q),
        .nxt_cfg (nxt_cfg)
    );

    assign run = (state_q != ST_OFF);

    gap_half_div u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .div       (act_q.div),
        .half_done (half_done)
    );

    assign tick_end = half_done && (state_q == ST_LOW || state_q == ST_GAP_B);
    assign wrap     = (pos_q >= act_q.len - 1'b1);
    assign pos_inc  = pos_q + 1'b1;

    // next-state process
    always_comb begin
        state_d = state_q;
        pos_d   = pos_q;
        load    = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                if (enable) begin
                    load    = 1'b1;
                    pos_d   = '0;
                    state_d = tick_in_gap(nxt_cfg, '0) ? ST_GAP_A : ST_HIGH;
                end
            end
            ST_HIGH: begin
                if (half_done) state_d = ST_LOW;
            end
            ST_GAP_A: begin
                if (half_done) state_d = ST_GAP_B;
            end
            ST_LOW, ST_GAP_B: begin
                if (tick_end) begin
                    if (wrap) begin
                        load    = 1'b1;
                        pos_d   = '0;
                        state_d = tick_in_gap(nxt_cfg, '0) ? ST_GAP_A : ST_HIGH;
                    end else begin
                        pos_d   = pos_inc;
                        state_d = tick_in_gap(act_q, pos_inc) ? ST_GAP_A : ST_HIGH;
                    end
                end
            end
        endcase
        if (!enable) begin
            state_d = ST_OFF;
            pos_d   = '0;
            load    = 1'b0;
        end
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            pos_q   <= '0;
        end else begin
            state_q <= state_d;
            pos_q   <= pos_d;
        end
    end

    // output process
    always_comb begin
        bclk     = (state_q == ST_HIGH);
        fsync    = run && (pos_q == '0);
        data_win = run && !((act_q.idle_start != act_q.idle_stop) &&
                            (pos_q >= act_q.idle_start));
        bit_pos  = pos_q;
    end

endmodule

// File: rtl/audio_clkgen_chk.sv
module audio_clkgen_chk
    import gap_clkgen_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                enable,
    input logic                bclk,
    input logic                fsync,
    input logic                data_win,
    input logic [CG_POS_W-1:0] bit_pos,
    input logic                gap_st,
    input gen_cfg_t            act_cfg
);

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!bclk && !fsync && !data_win && bit_pos == '0)); // R8

    AST_GAP_NO_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        gap_st |-> !data_win); // R4

    AST_GAP_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        gap_st |-> !bclk); // R3

    AST_POS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(bit_pos) && bit_pos != '0) |->
            ((bit_pos - $past(bit_pos)) == CG_POS_W'(1))); // R1

    AST_FSYNC_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fsync) |-> (bit_pos == '0)); // R2

    AST_LOAD_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_cfg) |-> (bit_pos == '0)); // R7

    AST_ACTIVE_SANE: assert property (@(posedge clk) disable iff (!rst_n)
        (act_cfg.idle_stop <= act_cfg.len) &&
        (act_cfg.idle_start <= act_cfg.idle_stop) &&
        (act_cfg.len >= CG_POS_W'(2)) && (act_cfg.div != '0)); // R6

endmodule

bind audio_clkgen audio_clkgen_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .bclk     (bclk),
    .fsync    (fsync),
    .data_win (data_win),
    .bit_pos  (bit_pos),
    .gap_st   (state_q == ST_GAP_A || state_q == ST_GAP_B),
    .act_cfg  (act_q)
);

// File: tb/test_audio_clkgen.sv
`timescale 1ns/1ps
module test_audio_clkgen;

    typedef struct {
        int pulses;
        int sys;
        int win;
        int fs;
    } frame_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [7:0] cfg_div = 8'd1, cfg_len = 8'd32, cfg_idle_start = 8'd0, cfg_idle_stop = 8'd0;
    logic       bclk, fsync, data_win;
    logic [7:0] bit_pos;

    int errors = 0, checks = 0, rises = 0;
    bit done = 0;
    frame_t exp_q[$];
    int e_div = 1, e_len = 32, e_start = 0, e_stop = 0;

    always #2.5 clk = ~clk;

    audio_clkgen i_audio_clkgen (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .cfg_div(cfg_div), .cfg_len(cfg_len),
        .cfg_idle_start(cfg_idle_start), .cfg_idle_stop(cfg_idle_stop),
        .bclk(bclk), .fsync(fsync), .data_win(data_win), .bit_pos(bit_pos)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // driver: applies a configuration and queues three expected frames
    task automatic apply(int div, int len, int st, int sp);
        frame_t f;
        cfg_div = 8'(div); cfg_len = 8'(len);
        cfg_idle_start = 8'(st); cfg_idle_stop = 8'(sp);
        // R6: only a valid setting replaces the tracked one
        if (div != 0 && len >= 2 && sp <= len && st <= sp) begin
            e_div = div; e_len = len; e_start = st; e_stop = sp;
        end
        f.sys = e_len * 2 * e_div;
        f.fs  = 2 * e_div;
        if (e_start != e_stop) begin
            f.pulses = e_len - (e_stop - e_start);
            f.win    = e_start * 2 * e_div;
        end else begin
            f.pulses = e_len;
            f.win    = e_len * 2 * e_div;
        end
        repeat (3) exp_q.push_back(f);
    endtask

    // monitor: measures whole frames between fsync rises
    int  m_pulses = 0, m_sys = 0, m_win = 0, m_fs = 0;
    bit  started = 0, bclk_p = 0, fs_p = 0;
    always @(negedge clk) begin
        if (rst_n && enable) begin
            if (fsync && !fs_p) begin
                check("R2 pos at fsync", int'(bit_pos), 0);
                if (started) begin
                    if (exp_q.size() == 0) begin
                        check("R7 queue empty", 1, 0);
                    end else begin
                        frame_t e;
                        e = exp_q.pop_front();
                        check("R1 frame cycles", m_sys, e.sys);
                        check("R3 R5 pulses", m_pulses, e.pulses);
                        check("R4 window cycles", m_win, e.win);
                        check("R2 fsync width", m_fs, e.fs);
                    end
                end
                started = 1;
                rises++;
                m_pulses = 0; m_sys = 0; m_win = 0; m_fs = 0;
            end
            m_sys++;
            if (bclk && !bclk_p) m_pulses++;
            if (data_win) m_win++;
            if (fsync) m_fs++;
        end
        bclk_p = bclk;
        fs_p   = fsync;
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: reset state
        check("R8 reset bclk", int'(bclk), 0);
        check("R8 reset fsync", int'(fsync), 0);
        check("R8 reset data_win", int'(data_win), 0);
        check("R8 reset bit_pos", int'(bit_pos), 0);
        rst_n = 1'b1;
        @(negedge clk);
        apply(2, 20, 12, 18);   // R3 R4 gap mid-frame
        enable = 1'b1;
        wait (rises >= 3); @(negedge clk);
        apply(1, 16, 5, 5);     // R5 equal start/stop
        wait (rises >= 6); @(negedge clk);
        apply(3, 10, 8, 12);    // R6 stop beyond len: rejected
        wait (rises >= 9); @(negedge clk);
        apply(3, 12, 0, 4);     // R4 gap from tick 0
        wait (rises >= 12); @(negedge clk);
        apply(1, 10, 6, 4);     // R6 start after stop: rejected
        wait (rises >= 15); @(negedge clk);
        apply(1, 8, 3, 8);      // R3 gap to the frame end
        wait (rises >= 18); @(negedge clk);
        enable = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R8 disabled bclk", int'(bclk), 0);
        check("R8 disabled fsync", int'(fsync), 0);
        check("R8 disabled data_win", int'(data_win), 0);
        check("R8 disabled bit_pos", int'(bit_pos), 0);
        done = 1;
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            finish_run();
        end
    end

endmodule